// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Control

The block holds two 16-bit down-counters, timer A and timer B, behind a byte-wide register bus with a 4-bit address. Each timer has three parts:

- A reload latch, which can only be written.
- A live counter, which can only be read. It sits at the same addresses as the latch.
- A control byte, which enables counting, selects one-shot operation, picks the count source, and offers a self-clearing force-load strobe.

When a counter runs out it reloads from its latch and raises its flag in a shared interrupt status byte. A mask decides whether that event also drives the active-low interrupt output.

Software arms an interrupt source by writing the interrupt control address with bit 7 set, and disarms it with bit 7 clear. A single read of that address does two things: it returns every pending flag together with the summary bit, and it clears them all. Timer B can count system clocks or timer A run-outs. This lets the two timers form one 32-bit interval.

The external count input is tied inactive in this build. The other legacy register addresses have no function.

Top module: `twin_timer`

## Requirements
- R1: After reset, every address reads 0x00 and irqN is high.
- R2: A write to 0x4/0x5 (timer A low/high) or 0x6/0x7 (timer B low/high) loads only the reload latch. A read of the same address returns the live counter byte.
- R3: Writing a control byte (0xE for A, 0xF for B) with bit 4 set copies the latch into the counter at that edge. The control byte always reads back with bit 4 clear.
- R4: A counter with control bit 0 set and a clock source selected decrements once per source tick. A tick that finds the counter at 1 or 0 reloads the latch instead, so with latch L the run-out comes every L ticks.
- R5: With control bit 3 set, the run-out that reloads the counter also clears control bit 0, and counting stops.
- R6: Timer A counts system clocks only when its bit 5 is 0. Timer B bits 6:5 select the source: 00 is the system clock, 10 is timer A run-outs, and 01 and 11 never count. Timer A with bit 5 set never counts.
- R7: A run-out sets status bit 0 (timer A) or bit 1 (timer B) at address 0xD, whatever the mask holds.
- R8: A write to 0xD with bit 7 = 1 sets the mask bits named in bits 4:0. With bit 7 = 0 it clears them. Other mask bits keep their values.
- R9: Status bit 7 sets, and irqN goes low, only on the edge where a source whose mask bit is 1 sets its flag.
- R10: A read of 0xD returns {bit7, 2'b00, flags[4:0]}. At that edge it clears all flags and bit 7, and irqN returns high. A run-out on that same edge is kept.
- R11: Addresses 0x0-0x3 and 0x8-0xC read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; clear-on-read side effects act at the edge |
| rdData | output | 8 | Read data for addr, combinational |
| irqN | output | 1 | Active-low interrupt request |

## Verification
A wrong counter value does not show up at once. It appears at the ports as a shifted run-out: the status flag and irqN change at the wrong edge, a fixed number of cycles after the force-load. Directed reads of the counter address pin the value down cycle by cycle.

A stuck control or mask bit shows within one run-out period. It appears either as a timer that keeps running after a one-shot event or as an interrupt that is raised while disarmed. A lost or doubled flag shows on the next status read, and the same-edge collision case is aimed at exactly that cycle.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int NUM_TMR = 2;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 2 * DATA_W;
  localparam int ADDR_W  = 4;
  localparam int SRC_W   = 5;

  // Address map anchors
  localparam int ADR_TMR_BASE = 4;    // timer i low byte at base + 2*i
  localparam int ADR_ICR      = 13;
  localparam int ADR_CTL_BASE = 14;   // control of timer i at base + i

  // Control bit positions
  localparam int CB_EN      = 0;
  localparam int CB_ONESHOT = 3;
  localparam int CB_FORCE   = 4;
  localparam int CB_SRC     = 5;

  // Interrupt byte bit positions
  localparam int IB_TOP = 7;

  // External count input tied inactive
  localparam logic CNT_LEVEL = 1'b0;

  typedef struct packed {
    logic [NUM_TMR-1:0] latchLo;
    logic [NUM_TMR-1:0] latchHi;
    logic [NUM_TMR-1:0] forceLd;
    logic [NUM_TMR-1:0] tick;
    logic [DATA_W-1:0]  wrByte;
  } tmrStrobe_t;
endpackage

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  tmrStrobe_t                     strb,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  cnt,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  latch,
  output logic [NUM_TMR-1:0]             atLast
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_lane
    logic [CNT_W-1:0] cntR;
    logic [CNT_W-1:0] latchR;
    logic             lastR;

    assign lastR = (cntR <= CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        latchR <= '0;
        cntR   <= '0;
      end else begin
        if (strb.latchLo[i]) latchR[DATA_W-1:0]     <= strb.wrByte;
        if (strb.latchHi[i]) latchR[CNT_W-1:DATA_W] <= strb.wrByte;
        if (strb.forceLd[i]) begin
          cntR <= latchR;
        end else if (strb.tick[i]) begin
          if (lastR) cntR <= latchR;
          else       cntR <= cntR - CNT_W'(1);
        end
      end
    end

    assign cnt[i]    = cntR;
    assign latch[i]  = latchR;
    assign atLast[i] = lastR;
  end
endmodule

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wrEn,
  input  logic [DATA_W-1:0]              wrData,
  input  logic                           rdEn,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt,
  input  logic [NUM_TMR-1:0]             atLast,
  output tmrStrobe_t                     strb,
  output logic [NUM_TMR-1:0]             under,
  output logic [NUM_TMR-1:0][DATA_W-1:0] ctrlReg,
  output logic [SRC_W-1:0]               maskBits,
  output logic [DATA_W-1:0]              rdData,
  output logic                           irqN
);
  localparam logic [DATA_W-1:0] FORCE_CLR = ~(DATA_W'(1) << CB_FORCE);

  assign strb.wrByte = wrData;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [DATA_W-1:0] ctl;
    logic              wrCtl;
    logic              srcOk;
    logic              tk;
    logic              un;
    logic              frc;

    assign wrCtl = wrEn && (addr == ADDR_W'(ADR_CTL_BASE + i));
    assign frc   = wrCtl && wrData[CB_FORCE];

    if (i == 0) begin : g_first
      assign srcOk = ~ctl[CB_SRC];
    end else begin : g_chain
      logic [1:0] mode;
      assign mode  = ctl[CB_SRC+1:CB_SRC];
      assign srcOk = (mode == 2'b00) |
                     ((mode == 2'b01) & CNT_LEVEL) |
                     ((mode == 2'b10) & g_tmr[i-1].un) |
                     ((mode == 2'b11) & g_tmr[i-1].un & CNT_LEVEL);
    end

    assign tk = ctl[CB_EN] & srcOk & ~frc;
    assign un = tk & atLast[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctl <= '0;
      end else if (wrCtl) begin
        ctl <= wrData & FORCE_CLR;
      end else if (un && ctl[CB_ONESHOT]) begin
        ctl[CB_EN] <= 1'b0;
      end
    end

    assign strb.latchLo[i] = wrEn && (addr == ADDR_W'(ADR_TMR_BASE + 2*i));
    assign strb.latchHi[i] = wrEn && (addr == ADDR_W'(ADR_TMR_BASE + 2*i + 1));
    assign strb.forceLd[i] = frc;
    assign strb.tick[i]    = tk;
    assign under[i]        = un;
    assign ctrlReg[i]      = ctl;
  end

  // Interrupt status and mask
  logic [SRC_W-1:0] flags;
  logic             sumR;
  logic [SRC_W-1:0] evt;
  logic             rdIcr;
  logic             wrIcr;

  assign evt   = {{(SRC_W-NUM_TMR){1'b0}}, under};
  assign rdIcr = rdEn && (addr == ADDR_W'(ADR_ICR));
  assign wrIcr = wrEn && (addr == ADDR_W'(ADR_ICR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskBits <= '0;
      flags    <= '0;
      sumR     <= 1'b0;
    end else begin
      if (wrIcr) begin
        if (wrData[IB_TOP]) maskBits <= maskBits | wrData[SRC_W-1:0];
        else                maskBits <= maskBits & ~wrData[SRC_W-1:0];
      end
      flags <= (rdIcr ? '0 : flags) | evt;
      sumR  <= (rdIcr ? 1'b0 : sumR) | (|(evt & maskBits));
    end
  end

  assign irqN = ~sumR;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr == ADDR_W'(ADR_TMR_BASE + 2*i))     rdData = cnt[i][DATA_W-1:0];
      if (addr == ADDR_W'(ADR_TMR_BASE + 2*i + 1)) rdData = cnt[i][CNT_W-1:DATA_W];
      if (addr == ADDR_W'(ADR_CTL_BASE + i))       rdData = ctrlReg[i];
    end
    if (addr == ADDR_W'(ADR_ICR)) begin
      rdData               = '0;
      rdData[IB_TOP]       = sumR;
      rdData[SRC_W-1:0]    = flags;
    end
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);
  tmrStrobe_t                     strb;
  logic [NUM_TMR-1:0]             under;
  logic [NUM_TMR-1:0]             atLast;
  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt;
  logic [NUM_TMR-1:0][CNT_W-1:0]  latch;
  logic [NUM_TMR-1:0][DATA_W-1:0] ctrlReg;
  logic [SRC_W-1:0]               maskBits;

  twin_timer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdEn    (rdEn),
    .cnt     (cnt),
    .atLast  (atLast),
    .strb    (strb),
    .under   (under),
    .ctrlReg (ctrlReg),
    .maskBits(maskBits),
    .rdData  (rdData),
    .irqN    (irqN)
  );

  twin_timer_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .cnt   (cnt),
    .latch (latch),
    .atLast(atLast)
  );
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic [ADDR_W-1:0]              addr,
  input logic                           wrEn,
  input logic                           rdEn,
  input logic                           irqN,
  input tmrStrobe_t                     strb,
  input logic [NUM_TMR-1:0]             under,
  input logic [NUM_TMR-1:0]             atLast,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  cnt,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  latch,
  input logic [NUM_TMR-1:0][DATA_W-1:0] ctrlReg,
  input logic [SRC_W-1:0]               maskBits
);
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick[0] && !atLast[0]) |=> (cnt[0] == $past(cnt[0]) - CNT_W'(1)));

  // R3
  force_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceLd[0] |=> (cnt[0] == $past(latch[0])));

  // R5
  oneshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (under[0] && ctrlReg[0][CB_ONESHOT] && !(wrEn && addr == ADDR_W'(ADR_CTL_BASE)))
      |=> !ctrlReg[0][CB_EN]);

  // R6
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[1][CB_SRC+1:CB_SRC] == 2'b10 && !under[0] && !strb.forceLd[1])
      |=> $stable(cnt[1]));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(|(under & maskBits[NUM_TMR-1:0])));

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(ADR_ICR) && !(|(under & maskBits[NUM_TMR-1:0])))
      |=> irqN);
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .irqN    (irqN),
  .strb    (strb),
  .under   (under),
  .atLast  (atLast),
  .cnt     (cnt),
  .latch   (latch),
  .ctrlReg (ctrlReg),
  .maskBits(maskBits)
);

// File: tb/twin_timer_bench.sv
module twin_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       irqN;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  twin_timer u_twin_timer (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic readExpect(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    doReset();
    for (int a = 0; a < 16; a++) readExpect("R1 reset value", 4'(a), 8'h00);
    check("R1 irqN after reset", {7'b0, irqN}, 8'h01);
  endtask

  task automatic t_latch();
    doReset();
    busWrite(4'h4, 8'h34); busWrite(4'h5, 8'h12);
    busWrite(4'h6, 8'h78); busWrite(4'h7, 8'h56);
    readExpect("R2 A low counter untouched", 4'h4, 8'h00);
    readExpect("R2 A high counter untouched", 4'h5, 8'h00);
    readExpect("R2 B low counter untouched", 4'h6, 8'h00);
    busWrite(4'hE, 8'h10);
    busWrite(4'hF, 8'h10);
    readExpect("R3 A low after force", 4'h4, 8'h34);
    readExpect("R3 A high after force", 4'h5, 8'h12);
    readExpect("R3 B low after force", 4'h6, 8'h78);
    readExpect("R3 B high after force", 4'h7, 8'h56);
    readExpect("R3 strobe reads clear", 4'hE, 8'h00);
  endtask

  task automatic t_count();
    doReset();
    busWrite(4'h4, 8'h05);
    busWrite(4'hE, 8'h11);
    readExpect("R4 count 5", 4'h4, 8'h05);
    readExpect("R4 count 4", 4'h4, 8'h04);
    readExpect("R4 count 3", 4'h4, 8'h03);
    readExpect("R4 count 2", 4'h4, 8'h02);
    readExpect("R4 count 1", 4'h4, 8'h01);
    readExpect("R4 reload", 4'h4, 8'h05);
    readExpect("R7 flag A unmasked", 4'hD, 8'h01);
    check("R9 irqN stays high unmasked", {7'b0, irqN}, 8'h01);
    busWrite(4'hE, 8'h00);
  endtask

  task automatic t_oneshot();
    doReset();
    busWrite(4'h4, 8'h03);
    busWrite(4'hE, 8'h19);
    readExpect("R3 ctrl readback", 4'hE, 8'h09);
    readExpect("R5 count 2", 4'h4, 8'h02);
    readExpect("R5 count 1", 4'h4, 8'h01);
    readExpect("R5 reloaded", 4'h4, 8'h03);
    readExpect("R5 enable cleared", 4'hE, 8'h08);
    readExpect("R5 stopped", 4'h4, 8'h03);
  endtask

  task automatic t_irq();
    doReset();
    busWrite(4'hD, 8'h81);
    busWrite(4'h4, 8'h02);
    busWrite(4'hE, 8'h19);
    idle(1);
    check("R9 irqN high before event", {7'b0, irqN}, 8'h01);
    idle(1);
    check("R9 irqN low on masked event", {7'b0, irqN}, 8'h00);
    readExpect("R10 status with summary", 4'hD, 8'h81);
    check("R10 irqN released by read", {7'b0, irqN}, 8'h01);
    readExpect("R10 status cleared", 4'hD, 8'h00);
    busWrite(4'hD, 8'h01);
    busWrite(4'hE, 8'h19);
    idle(2);
    check("R8 mask cleared no irq", {7'b0, irqN}, 8'h01);
    readExpect("R8 flag without summary", 4'hD, 8'h01);
    busWrite(4'hD, 8'h82);
    busWrite(4'hE, 8'h19);
    idle(2);
    check("R8 other bit set leaves A off", {7'b0, irqN}, 8'h01);
    readExpect("R8 status A only", 4'hD, 8'h01);
  endtask

  task automatic t_collide();
    doReset();
    busWrite(4'hD, 8'h81);
    busWrite(4'h4, 8'h02);
    busWrite(4'hE, 8'h19);
    idle(1);
    readExpect("R10 read before event", 4'hD, 8'h00);
    check("R10 event kept irqN", {7'b0, irqN}, 8'h00);
    readExpect("R10 event kept status", 4'hD, 8'h81);
  endtask

  task automatic t_chain();
    doReset();
    busWrite(4'h6, 8'h03);
    busWrite(4'hF, 8'h51);
    busWrite(4'h4, 8'h02);
    busWrite(4'hE, 8'h11);
    idle(2);
    readExpect("R6 B stepped by A run-out", 4'h6, 8'h02);
    readExpect("R6 B ctrl readback", 4'hF, 8'h41);
    idle(2);
    readExpect("R6 B reloaded", 4'h6, 8'h03);
    readExpect("R7 flags A and B", 4'hD, 8'h03);
    busWrite(4'hE, 8'h00);
  endtask

  task automatic t_sources();
    doReset();
    busWrite(4'h6, 8'h04);
    busWrite(4'hF, 8'h11);
    readExpect("R6 B clock mode 4", 4'h6, 8'h04);
    readExpect("R6 B clock mode 3", 4'h6, 8'h03);
    busWrite(4'hF, 8'h31);
    idle(4);
    readExpect("R6 B mode 01 holds", 4'h6, 8'h04);
    readExpect("R6 B mode 01 ctrl", 4'hF, 8'h21);
    busWrite(4'hF, 8'h71);
    idle(4);
    readExpect("R6 B mode 11 holds", 4'h6, 8'h04);
    busWrite(4'h4, 8'h03);
    busWrite(4'hE, 8'h31);
    idle(5);
    readExpect("R6 A external source holds", 4'h4, 8'h03);
    readExpect("R6 no flags", 4'hD, 8'h00);
  endtask

  task automatic t_unused();
    doReset();
    busWrite(4'h0, 8'hFF);
    busWrite(4'h3, 8'hFF);
    busWrite(4'h8, 8'hFF);
    busWrite(4'hC, 8'hFF);
    readExpect("R11 addr 0", 4'h0, 8'h00);
    readExpect("R11 addr 3", 4'h3, 8'h00);
    readExpect("R11 addr 8", 4'h8, 8'h00);
    readExpect("R11 addr C", 4'hC, 8'h00);
    readExpect("R11 ctrl A untouched", 4'hE, 8'h00);
    readExpect("R11 status untouched", 4'hD, 8'h00);
    check("R11 irqN untouched", {7'b0, irqN}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_latch();
    t_count();
    t_oneshot();
    t_irq();
    t_collide();
    t_chain();
    t_sources();
    t_unused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #1000000;
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule